// File: doc/BRIEF.md
# Ternary Stability Classifying Response Generator

This block builds a device-unique response from a bank of N external bit sources, such as cross-coupled latch cells or repeated evaluations of one challenge. Each source is observed for a fixed window of accepted samples and given a two-bit ternary code. The codes are: steady low, steady high, or "toggling". A toggling source is not thrown away. It becomes a third stable symbol, so the location of the unstable cells adds entropy to the response instead of reducing it.

A single classifier is shared by all sources and visits them in order 0 to N-1. A select output steers an external multiplexer to the source under observation, and a source-enable output gates the bank so that the sources run only while a response is being built. Samples arrive on a valid/ready stream. A sample counts only in a cycle where both `sample_valid` and `sample_ready` are high. The producer may hold `sample_valid` low for any number of cycles, and those cycles do not count. `sample_ready` is high exactly while the block is busy. A sample offered while it is low is dropped, and the producer must keep offering it until it is accepted. Control is a plain start/busy/done handshake. The 2N-bit result is held on `response` after completion.

Top module: `ternpuf_classifier`

## Requirements
- R1: A source whose WINDOW accepted samples are all 0 receives code 2'b00.
- R2: A source whose WINDOW accepted samples are all 1 receives code 2'b11.
- R3: If any two consecutive accepted samples of a source differ, its code is 2'b10. This holds even if the change is on the final sample, and even if the stream later returns to its first value.
- R4: No slot of `response` ever holds 2'b01.
- R5: The code of source i is placed at `response[2i+1:2i]`, so higher source indices occupy more significant bits.
- R6: Exactly WINDOW accepted samples are consumed per source. Cycles with `sample_valid` low do not advance the window.
- R7: `src_sel` visits sources 0, 1, …, N-1 in order. It holds its value for the whole window of each source.
- R8: `src_en` is high exactly while `busy` is high, and low otherwise.
- R9: A `start` while idle sets `busy` on the next cycle with `src_sel` = 0 and clears `response` to zero. A `start` while busy is ignored.
- R10: `done` is a one-cycle pulse in the cycle after the final sample of source N-1 is accepted, with `busy` already low. `response` then holds until the next `start`.
- R11: After reset, `busy`, `done`, `src_en` and `sample_ready` are 0 and `response` is all zeros.
- R12: While idle, `sample_ready` is 0, and offered samples leave `response` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin building a response (honoured only when idle) |
| busy | output | 1 | A response is being built |
| done | output | 1 | One-cycle pulse when the response is complete |
| src_en | output | 1 | Enable/clock gate for the source bank |
| src_sel | output | SEL_W | Index of the source under observation |
| sample_bit | input | 1 | Sample value from the selected source |
| sample_valid | input | 1 | Sample present on `sample_bit` |
| sample_ready | output | 1 | Classifier accepts a sample this cycle |
| response | output | 2*N_SRC | Concatenated ternary codes, source i at bits [2i+1:2i] |

## Verification
The hardest case to reach from the ports is a heavily biased source that changes value only once, on the very last sample of its window. Stalls on the sample stream must also move the window boundary without moving the classification. To reach this, the stimulus places single transitions at chosen positions, including the last one. It adds short pulses that return to the starting value, and it gaps `sample_valid` randomly at several densities. The expected codes come from the bits actually accepted, so stalled cycles cannot hide a miscount.

// File: rtl/ternpuf_pkg.sv
package ternpuf_pkg;

  typedef enum logic [1:0] {
    CODE_LOW    = 2'b00,
    CODE_TOGGLE = 2'b10,
    CODE_HIGH   = 2'b11
  } tcode_e;

  typedef enum logic [0:0] {
    SEQ_IDLE    = 1'b0,
    SEQ_OBSERVE = 1'b1
  } seq_state_e;

  function automatic tcode_e classify(input logic toggled, input logic level);
    if (toggled) return CODE_TOGGLE;
    else if (level) return CODE_HIGH;
    else return CODE_LOW;
  endfunction

endpackage

// File: rtl/ternpuf_detector.sv
module ternpuf_detector
  import ternpuf_pkg::*;
#(
  parameter int WINDOW = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       accept,
  input  logic       bit_in,
  output logic       code_valid,
  output logic [1:0] code
);
  localparam int CNT_W = (WINDOW > 1) ? $clog2(WINDOW) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WINDOW - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             prev_q;
  logic             tog_q;
  logic             is_first;
  logic             is_last;
  logic             tog_next;
  tcode_e           code_e;

  always_comb begin
    is_first   = (cnt_q == '0);
    is_last    = (cnt_q == LAST_IDX);
    tog_next   = tog_q | (!is_first && (bit_in != prev_q));
    code_e     = classify(tog_next, bit_in);
    code       = code_e;
    code_valid = accept && is_last;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      prev_q <= 1'b0;
      tog_q  <= 1'b0;
    end else if (clear || (accept && is_last)) begin
      cnt_q  <= '0;
      prev_q <= 1'b0;
      tog_q  <= 1'b0;
    end else if (accept) begin
      cnt_q  <= cnt_q + 1'b1;
      prev_q <= bit_in;
      tog_q  <= tog_next;
    end
  end

  // R3
  sticky_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !is_last && !clear && tog_q) |=> tog_q)
    else $error("toggle flag dropped inside a window");

  // R6
  window_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST_IDX)
    else $error("window counter beyond window length");

endmodule

// File: rtl/ternpuf_sequencer.sv
module ternpuf_sequencer
  import ternpuf_pkg::*;
#(
  parameter int N_SRC = 128,
  parameter int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             adv,
  output logic             busy,
  output logic             done,
  output logic             launch,
  output logic [SEL_W-1:0] src_sel
);
  localparam logic [SEL_W-1:0] LAST_SRC = SEL_W'(N_SRC - 1);

  seq_state_e       state_q;
  logic [SEL_W-1:0] idx_q;
  logic             done_q;

  always_comb begin
    busy    = (state_q == SEQ_OBSERVE);
    launch  = (state_q == SEQ_IDLE) && start;
    src_sel = idx_q;
    done    = done_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        SEQ_IDLE: begin
          if (start) begin
            state_q <= SEQ_OBSERVE;
            idx_q   <= '0;
          end
        end
        SEQ_OBSERVE: begin
          if (adv) begin
            if (idx_q == LAST_SRC) begin
              state_q <= SEQ_IDLE;
              done_q  <= 1'b1;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done)
    else $error("done longer than one cycle");

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy)
    else $error("done while busy");

  // R7
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !adv) |=> (busy && $stable(src_sel)))
    else $error("select moved inside a window");

  // R9
  start_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && src_sel == '0))
    else $error("start from idle did not launch at source 0");

endmodule

// File: rtl/ternpuf_resp_store.sv
module ternpuf_resp_store
  import ternpuf_pkg::*;
#(
  parameter int N_SRC = 128,
  parameter int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  parameter int RESP_W = 2 * N_SRC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              busy,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_idx,
  input  logic [1:0]        wr_code,
  output logic [RESP_W-1:0] resp
);
  logic [RESP_W-1:0] resp_q;

  for (genvar i = 0; i < N_SRC; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
        resp_q[2*i +: 2] <= 2'b00;
      end else if (wr_en && (wr_idx == SEL_W'(i))) begin
        resp_q[2*i +: 2] <= wr_code;
      end
    end

    // R4
    no_code01_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resp_q[2*i +: 2] != 2'b01)
      else $error("slot holds the unused code");
  end

  assign resp = resp_q;

  // R10
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !clear) |=> $stable(resp_q))
    else $error("response changed while idle");

endmodule

// File: rtl/ternpuf_classifier.sv
module ternpuf_classifier
  import ternpuf_pkg::*;
#(
  parameter int N_SRC  = 128,
  parameter int WINDOW = 1000,
  parameter int SEL_W  = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  output logic               busy,
  output logic               done,
  output logic               src_en,
  output logic [SEL_W-1:0]   src_sel,
  input  logic               sample_bit,
  input  logic               sample_valid,
  output logic               sample_ready,
  output logic [2*N_SRC-1:0] response
);
  logic       launch;
  logic       accept;
  logic       code_valid;
  logic [1:0] code;
  logic       busy_w;

  assign sample_ready = busy_w;
  assign src_en       = busy_w;
  assign busy         = busy_w;
  assign accept       = sample_valid && busy_w;

  ternpuf_sequencer #(.N_SRC(N_SRC), .SEL_W(SEL_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .adv     (code_valid),
    .busy    (busy_w),
    .done    (done),
    .launch  (launch),
    .src_sel (src_sel)
  );

  ternpuf_detector #(.WINDOW(WINDOW)) u_det (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (launch),
    .accept     (accept),
    .bit_in     (sample_bit),
    .code_valid (code_valid),
    .code       (code)
  );

  ternpuf_resp_store #(.N_SRC(N_SRC), .SEL_W(SEL_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (launch),
    .busy    (busy_w),
    .wr_en   (code_valid),
    .wr_idx  (src_sel),
    .wr_code (code),
    .resp    (response)
  );

  // R8
  gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!src_en && !sample_ready))
    else $error("sources still enabled at completion");

endmodule

// File: tb/tb_ternpuf_classifier.sv
module tb_ternpuf_classifier;
  localparam int NS  = 8;
  localparam int WIN = 16;
  localparam int SW  = 3;
  localparam int RW  = 2 * NS;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          busy, done, src_en, sample_ready;
  logic [SW-1:0] src_sel;
  logic          sample_bit = 1'b0;
  logic          sample_valid = 1'b0;
  logic [RW-1:0] response;

  int n_checks = 0;
  int n_fail   = 0;

  int kind [NS];
  int tpos [NS];
  bit base [NS];
  int kcnt [NS];
  bit t_first[NS];
  bit t_prev [NS];
  bit t_tog  [NS];

  ternpuf_classifier #(.N_SRC(NS), .WINDOW(WIN), .SEL_W(SW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .src_en(src_en), .src_sel(src_sel), .sample_bit(sample_bit),
    .sample_valid(sample_valid), .sample_ready(sample_ready),
    .response(response)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit src_bit(input int i);
    int k = kcnt[i];
    case (kind[i])
      0: return 1'b0;
      1: return 1'b1;
      2: return (k >= tpos[i]) ? ~base[i] : base[i];
      3: return (k >= tpos[i] && k < tpos[i] + 2) ? ~base[i] : base[i];
      default: return 1'($urandom % 2);
    endcase
  endfunction

  function automatic logic [1:0] exp_code(input int i);
    if (t_tog[i]) return 2'b10;
    return t_prev[i] ? 2'b11 : 2'b00;
  endfunction

  task automatic set_all(input int kd, input int tp, input bit b);
    for (int i = 0; i < NS; i++) begin
      kind[i] = kd; tpos[i] = tp; base[i] = b;
    end
  endtask

  task automatic set_random();
    for (int i = 0; i < NS; i++) begin
      kind[i] = $urandom % 5;
      tpos[i] = 1 + ($urandom % (WIN - 1));
      base[i] = 1'($urandom % 2);
    end
  endtask

  task automatic run_resp(input int vpct, input bit mid_start);
    int acc = 0;
    int cycles = 0;
    bit got_done = 0;
    bit pend = 0;
    int pend_sel = 0;
    logic [RW-1:0] exp_resp;
    logic [RW-1:0] held;
    for (int i = 0; i < NS; i++) begin
      kcnt[i] = 0; t_first[i] = 1; t_prev[i] = 0; t_tog[i] = 0;
    end
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy === 1'b1, "R9", "busy after start", 64'(busy), 1);
    chk(response === '0, "R9", "response cleared on start", 64'(response), 0);
    chk(src_sel === '0, "R9", "first source", 64'(src_sel), 0);
    chk(src_en === 1'b1, "R8", "src_en while busy", 64'(src_en), 1);
    while (!got_done && cycles < 5000) begin
      if (done === 1'b1) begin
        got_done = 1;
      end else begin
        if (pend) begin
          chk(busy === 1'b1 && int'(src_sel) == pend_sel, "R9",
              "start while busy ignored", 64'(src_sel), 64'(pend_sel));
          pend = 0;
        end
        chk(src_en === busy, "R8", "src_en tracks busy", 64'(src_en), 64'(busy));
        begin
          bit v = (($urandom % 100) < vpct);
          int cur = int'(src_sel);
          bit b = v ? src_bit(cur) : 1'($urandom % 2);
          if (v && sample_ready === 1'b1) begin
            chk(cur == acc / WIN, "R7", "select order", 64'(cur), 64'(acc / WIN));
            if (!t_first[cur] && b != t_prev[cur]) t_tog[cur] = 1;
            t_first[cur] = 0;
            t_prev[cur] = b;
            kcnt[cur]++;
            acc++;
          end
          if (mid_start && acc == WIN + 3 && !pend && cycles > 0 && !v) begin
            start = 1'b1;
            pend = 1;
            pend_sel = int'(src_sel);
          end
          sample_valid = v;
          sample_bit = b;
        end
        @(negedge clk);
        start = 1'b0;
        cycles++;
      end
    end
    sample_valid = 1'b0;
    chk(got_done, "R10", "watchdog: done seen", 64'(cycles), 0);
    if (got_done) begin
      chk(busy === 1'b0, "R10", "busy low with done", 64'(busy), 0);
      chk(acc == NS * WIN, "R6", "accepted sample count", 64'(acc), 64'(NS * WIN));
      for (int i = 0; i < NS; i++) exp_resp[2*i +: 2] = exp_code(i);
      chk(response === exp_resp, "R5", "full response", 64'(response), 64'(exp_resp));
      for (int i = 0; i < NS; i++) begin
        logic [1:0] e = exp_code(i);
        string rq = (e == 2'b10) ? "R3" : ((e == 2'b11) ? "R2" : "R1");
        chk(response[2*i +: 2] === e, rq, $sformatf("slot %0d", i),
            64'(response[2*i +: 2]), 64'(e));
        chk(response[2*i +: 2] !== 2'b01, "R4", "unused code", 64'(response[2*i +: 2]), 0);
      end
      held = response;
      @(negedge clk);
      chk(done === 1'b0, "R10", "done one cycle", 64'(done), 0);
      chk(response === held, "R10", "response holds", 64'(response), 64'(held));
    end
  endtask

  task automatic idle_poke();
    logic [RW-1:0] held = response;
    for (int c = 0; c < 8; c++) begin
      sample_valid = 1'b1;
      sample_bit = 1'($urandom % 2);
      @(negedge clk);
      chk(sample_ready === 1'b0, "R12", "ready low in idle", 64'(sample_ready), 0);
      chk(src_en === 1'b0, "R8", "src_en low in idle", 64'(src_en), 0);
    end
    sample_valid = 1'b0;
    chk(response === held, "R12", "idle samples ignored", 64'(response), 64'(held));
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0, "R11", "busy after reset", 64'(busy), 0);
    chk(done === 1'b0, "R11", "done after reset", 64'(done), 0);
    chk(src_en === 1'b0, "R11", "src_en after reset", 64'(src_en), 0);
    chk(sample_ready === 1'b0, "R11", "ready after reset", 64'(sample_ready), 0);
    chk(response === '0, "R11", "response after reset", 64'(response), 0);

    set_all(0, 1, 0); run_resp(100, 0);
    set_all(1, 1, 0); run_resp(60, 0);
    idle_poke();
    set_all(2, WIN - 1, 0); run_resp(100, 0);
    set_all(2, WIN - 1, 1); run_resp(40, 0);
    set_all(3, 1, 1); run_resp(70, 0);
    set_all(2, 1, 0); run_resp(30, 1);
    idle_poke();
    for (int r = 0; r < 12; r++) begin
      set_random();
      run_resp(20 + ($urandom % 81), (r % 3) == 0);
    end
    idle_poke();

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #1500000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule